// File: doc/BRIEF.md
# Mip-map Level Address Generator

This block lays out a mip-mapped texture inside a single rectangular region of memory and reports where each level lives. A start pulse captures the region's base address, the row pitch (given as a log2 byte count), the level-0 width and height in texels and the log2 texel size. The block then walks from the full-size level down to the 1x1 level and emits one record per level on a valid/ready stream. Each record carries the level index, the byte address of its upper-left texel, its width, its height and a flag on the final record.

Levels share the base column and the pitch. Each level is stacked directly under the one before it. Its first row is pushed down as far as needed so that its upper-left corner lands on a 16-byte boundary. Before a walk begins, the captured parameters are checked. Any violation raises an error flag, and no records are produced.

Top module: `mip_addr_gen`

## Requirements
- R1: After reset, rec_valid_o, busy_o and err_o are all low.
- R2: If a start is accepted while base_i has any of its low 12 bits set, err_o goes high in the cycle after the start and no record is emitted.
- R3: If 2^pitch_log2_i is smaller than width_i × 2^bpt_log2_i, the start is rejected with err_o high and no records. A pitch exactly equal to the level-0 row size is accepted.
- R4: If bpt_log2_i is above 2, or if width_i or height_i is zero or not a power of two, the start is rejected with err_o high and no records.
- R5: A valid start emits records with rec_level_o counting up from 0. Width and height halve at each step and clamp at 1. The record whose width and height are both 1 has rec_last_o high and is the final record.
- R6: rec_addr_o equals base_i + row × 2^pitch_log2_i, where row is 0 for level 0. For each later level, row starts at the previous row plus the previous height and is rounded up to the smallest value for which row × 2^pitch_log2_i is a multiple of 16. For example, a 4x8 map at 2 bytes per texel with an 8-byte pitch gives offsets 0, 64, 96 and 112.
- R7: While rec_valid_o is high and rec_ready_i is low, every record field stays unchanged.
- R8: The first record is presented in the cycle after an accepted start. busy_o is high from that cycle until the handshake of the final record. A start_i pulse while busy_o is high is ignored.
- R9: err_o is updated only when a start is accepted while idle, and then holds until the next such start. A good start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; parameters are captured with it |
| base_i | input | ADDR_W | Byte address of the upper-left corner of level 0 |
| pitch_log2_i | input | PL_W | log2 of the row pitch in bytes |
| width_i | input | DIM_W | Level-0 width in texels |
| height_i | input | DIM_W | Level-0 height in texels |
| bpt_log2_i | input | 2 | log2 of bytes per texel |
| busy_o | output | 1 | A walk is in progress |
| err_o | output | 1 | The last accepted start had invalid parameters |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Record accepted by the consumer |
| rec_level_o | output | LVL_W | Level index |
| rec_addr_o | output | ADDR_W | Byte address of the level's upper-left texel |
| rec_width_o | output | DIM_W | Level width in texels |
| rec_height_o | output | DIM_W | Level height in texels |
| rec_last_o | output | 1 | This is the 1x1 level |

## Verification
A table of layouts drives most of the tests. Tall, wide, square and single-texel maps show whether width and height clamp independently. Pitches of 1, 4, 8, 16 and 64 bytes show whether the row round-up toward 16 bytes is applied only when the pitch is under 16 bytes. Pitches equal to or just under the row size tell the accepted case from the rejected one. Misaligned bases, oversized texels and zero or non-power-of-two sizes test each error cause on its own. Directed runs stall the stream, pulse start mid-walk, and chain a bad start into a good one, which shows that records hold, restarts are ignored and the error flag clears.

// File: rtl/mip_pkg.sv
package mip_pkg;
  typedef enum logic {ST_IDLE, ST_EMIT} walk_st_e;
  localparam int unsigned ALIGN_LOG = 4;   // level corner granularity: 16 bytes
  localparam int unsigned BASE_LOG  = 12;  // base granularity: 4 KB
  localparam int unsigned MAX_BPT   = 2;
endpackage

// File: rtl/mip_param_check.sv
module mip_param_check #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 12,
  parameter int unsigned PL_W   = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PL_W-1:0]   pitch_log2_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [1:0]        bpt_log2_i,
  output logic              ok_o
);
  import mip_pkg::*;

  logic [PL_W-1:0] w_log;
  logic [PL_W:0]   need_log;
  logic base_ok, bpt_ok, w_ok, h_ok, pitch_ok;

  always_comb begin
    w_log = '0;
    for (int i = 0; i < DIM_W; i++)
      if (width_i[i]) w_log = PL_W'(i);
  end

  assign need_log = {1'b0, w_log} + (PL_W+1)'(bpt_log2_i);
  assign base_ok  = (base_i[BASE_LOG-1:0] == '0);
  assign bpt_ok   = (32'(bpt_log2_i) <= MAX_BPT);
  assign w_ok     = (width_i != '0) && ((width_i & (width_i - 1'b1)) == '0);
  assign h_ok     = (height_i != '0) && ((height_i & (height_i - 1'b1)) == '0);
  // row size is a power of two once width is, so compare exponents
  assign pitch_ok = ({1'b0, pitch_log2_i} >= need_log);
  assign ok_o     = base_ok & bpt_ok & w_ok & h_ok & pitch_ok;
endmodule

// File: rtl/mip_row_align.sv
module mip_row_align #(
  parameter int unsigned ROW_W = 15,
  parameter int unsigned PL_W  = 5
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [PL_W-1:0]  pitch_log2_i,
  output logic [ROW_W-1:0] row_o
);
  import mip_pkg::*;

  logic [PL_W-1:0]  sh;
  logic [ROW_W-1:0] mask;

  assign sh   = PL_W'(ALIGN_LOG) - pitch_log2_i;
  assign mask = (ROW_W'(1) << sh) - ROW_W'(1);

  always_comb begin
    if (32'(pitch_log2_i) >= ALIGN_LOG) row_o = row_i;
    else                                row_o = (row_i + mask) & ~mask;
  end
endmodule

// File: rtl/mip_level_walker.sv
module mip_level_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 12,
  parameter int unsigned PL_W   = 5,
  localparam int unsigned LVL_W = $clog2(DIM_W + 1),
  localparam int unsigned ROW_W = DIM_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ok_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PL_W-1:0]   pitch_log2_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              rec_ready_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rec_valid_o,
  output logic [LVL_W-1:0]  rec_level_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [DIM_W-1:0]  rec_width_o,
  output logic [DIM_W-1:0]  rec_height_o,
  output logic              rec_last_o
);
  import mip_pkg::*;

  walk_st_e          st_q;
  logic [ADDR_W-1:0] base_q;
  logic [PL_W-1:0]   pitch_q;
  logic [ROW_W-1:0]  row_q, row_next;
  logic [DIM_W-1:0]  w_q, h_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              err_q;
  logic              fire, last;

  mip_row_align #(.ROW_W(ROW_W), .PL_W(PL_W)) u_align (
    .row_i       (row_q + ROW_W'(h_q)),
    .pitch_log2_i(pitch_q),
    .row_o       (row_next)
  );

  assign last = (w_q == DIM_W'(1)) && (h_q == DIM_W'(1));
  assign fire = (st_q == ST_EMIT) && rec_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      base_q  <= '0;
      pitch_q <= '0;
      row_q   <= '0;
      w_q     <= '0;
      h_q     <= '0;
      lvl_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          err_q <= !ok_i;
          if (ok_i) begin
            st_q    <= ST_EMIT;
            base_q  <= base_i;
            pitch_q <= pitch_log2_i;
            row_q   <= '0;
            w_q     <= width_i;
            h_q     <= height_i;
            lvl_q   <= '0;
          end
        end
        ST_EMIT: if (fire) begin
          if (last) st_q <= ST_IDLE;
          else begin
            row_q <= row_next;
            w_q   <= (w_q > DIM_W'(1)) ? (w_q >> 1) : w_q;
            h_q   <= (h_q > DIM_W'(1)) ? (h_q >> 1) : h_q;
            lvl_q <= lvl_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q == ST_EMIT);
  assign rec_valid_o  = (st_q == ST_EMIT);
  assign err_o        = err_q;
  assign rec_level_o  = lvl_q;
  assign rec_addr_o   = base_q + (ADDR_W'(row_q) << pitch_q);
  assign rec_width_o  = w_q;
  assign rec_height_o = h_q;
  assign rec_last_o   = last;

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_addr_o) &&
      $stable(rec_level_o) && $stable(rec_width_o) && $stable(rec_height_o));
  a_r5_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !rec_last_o |=> rec_level_o == $past(rec_level_o) + 1'b1);
  a_r5_stop_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && rec_last_o |=> !rec_valid_o);
  a_r5_dims_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> $countones(rec_width_o) == 1 && $countones(rec_height_o) == 1);
  a_r2_err_no_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rec_valid_o);
  a_r8_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(fire && rec_last_o) |=> busy_o);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && !busy_o) |=> $stable(err_o));
endmodule

// File: rtl/mip_addr_gen.sv
module mip_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DIM_W  = 12,
  parameter int unsigned PL_W   = 5,
  localparam int unsigned LVL_W = $clog2(DIM_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PL_W-1:0]   pitch_log2_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [1:0]        bpt_log2_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [LVL_W-1:0]  rec_level_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [DIM_W-1:0]  rec_width_o,
  output logic [DIM_W-1:0]  rec_height_o,
  output logic              rec_last_o
);
  logic params_ok;

  mip_param_check #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PL_W(PL_W)) u_check (
    .base_i      (base_i),
    .pitch_log2_i(pitch_log2_i),
    .width_i     (width_i),
    .height_i    (height_i),
    .bpt_log2_i  (bpt_log2_i),
    .ok_o        (params_ok)
  );

  mip_level_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PL_W(PL_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ok_i        (params_ok),
    .base_i      (base_i),
    .pitch_log2_i(pitch_log2_i),
    .width_i     (width_i),
    .height_i    (height_i),
    .rec_ready_i (rec_ready_i),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .rec_valid_o (rec_valid_o),
    .rec_level_o (rec_level_o),
    .rec_addr_o  (rec_addr_o),
    .rec_width_o (rec_width_o),
    .rec_height_o(rec_height_o),
    .rec_last_o  (rec_last_o)
  );

  // base is 4 KB aligned on any accepted walk, so every corner is 16-byte aligned
  a_r6_corner_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> rec_addr_o[3:0] == 4'd0);
endmodule

// File: tb/tb_mip_addr_gen.sv
module tb_mip_addr_gen;
  localparam int ADDR_W = 32;
  localparam int DIM_W  = 12;
  localparam int PL_W   = 5;
  localparam int LVL_W  = $clog2(DIM_W + 1);

  typedef struct packed {
    logic [31:0] base;
    logic [4:0]  pl;
    logic [11:0] w;
    logic [11:0] h;
    logic [1:0]  bpt;
    logic        bad;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0000, 5'd3, 12'd4,  12'd8, 2'd1, 1'b0},
    '{32'h0002_0000, 5'd6, 12'd32, 12'd8, 2'd1, 1'b0},
    '{32'h0000_1000, 5'd2, 12'd1,  12'd4, 2'd2, 1'b0},
    '{32'h0000_3000, 5'd4, 12'd16, 12'd1, 2'd0, 1'b0},
    '{32'h0000_4000, 5'd1, 12'd1,  12'd1, 2'd0, 1'b0},
    '{32'h0000_B000, 5'd0, 12'd1,  12'd8, 2'd0, 1'b0},
    '{32'h0000_5800, 5'd6, 12'd4,  12'd4, 2'd0, 1'b1},
    '{32'h0000_6000, 5'd5, 12'd32, 12'd4, 2'd1, 1'b1},
    '{32'h0000_7000, 5'd2, 12'd2,  12'd2, 2'd2, 1'b1},
    '{32'h0000_8000, 5'd6, 12'd4,  12'd4, 2'd3, 1'b1},
    '{32'h0000_9000, 5'd6, 12'd12, 12'd4, 2'd0, 1'b1},
    '{32'h0000_A000, 5'd6, 12'd8,  12'd0, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic [PL_W-1:0] pl = '0;
  logic [DIM_W-1:0] w = '0, h = '0;
  logic [1:0] bpt = '0;
  logic ready = 1'b0;
  logic busy, err, valid, last;
  logic [LVL_W-1:0] lvl;
  logic [ADDR_W-1:0] addr;
  logic [DIM_W-1:0] rw, rh;

  int checks = 0, failures = 0, cyc = 0;

  always #10 clk = ~clk;

  mip_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PL_W(PL_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .pitch_log2_i(pl), .width_i(w), .height_i(h), .bpt_log2_i(bpt),
    .busy_o(busy), .err_o(err), .rec_valid_o(valid), .rec_ready_i(ready),
    .rec_level_o(lvl), .rec_addr_o(addr), .rec_width_o(rw),
    .rec_height_o(rh), .rec_last_o(last)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    base = v.base; pl = v.pl; w = v.w; h = v.h; bpt = v.bpt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // walk records against a row-by-row model; stall on odd levels when asked
  task automatic walk(input vec_t v, input bit stall);
    int row = 0;
    int ew = int'(v.w), eh = int'(v.h);
    logic [31:0] ea;
    for (int l = 0; l < 16; l++) begin
      ea = v.base + (32'(row) << v.pl);
      chk(valid == 1'b1 && busy == 1'b1, "R8", "valid/busy during walk", {valid, busy}, 2'b11);
      chk(lvl == LVL_W'(l), "R5", "level", lvl, l);
      chk(rw == DIM_W'(ew) && rh == DIM_W'(eh), "R5", "dims", {rw, rh}, {DIM_W'(ew), DIM_W'(eh)});
      chk(addr == ea, "R6", "address", addr, ea);
      chk(last == (ew == 1 && eh == 1), "R5", "last flag", last, (ew == 1 && eh == 1));
      if (stall && l[0]) begin
        start = 1'b1;   // R8: restart while busy must be ignored
        @(negedge clk);
        start = 1'b0;
        chk(valid && lvl == LVL_W'(l) && addr == ea && rw == DIM_W'(ew),
            "R7", "held under stall", {valid, addr}, {1'b1, ea});
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      if (ew == 1 && eh == 1) begin
        chk(!valid && !busy, "R8", "idle after last", {valid, busy}, 2'b00);
        chk(err == 1'b0, "R9", "err low after good walk", err, 0);
        return;
      end
      row = row + eh;
      while (((row << v.pl) % 16) != 0) row++;
      if (ew > 1) ew = ew / 2;
      if (eh > 1) eh = eh / 2;
    end
    chk(1'b0, "R5", "walk did not end", 16, 0);
  endtask

  task automatic expect_err(input vec_t v);
    launch(v);
    chk(err == 1'b1 && valid == 1'b0, "R2/R3/R4", "rejected start", {err, valid}, 2'b10);
    @(negedge clk);
    @(negedge clk);
    chk(err == 1'b1 && valid == 1'b0 && busy == 1'b0, "R9", "error holds, no records",
        {err, valid, busy}, 3'b100);
  endtask

  initial begin
    vec_t v;
    #35;
    chk(!valid && !busy && !err, "R1", "reset state", {valid, busy, err}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].bad) expect_err(VECS[i]);
      else begin
        launch(VECS[i]);
        walk(VECS[i], 1'b0);
      end
    end

    // R6 worked example: 4x8 @ 2 B/texel, 8 B pitch, with stalls
    v = VECS[0];
    launch(v);
    chk(addr == v.base, "R6", "example level 0", addr, v.base);
    walk(v, 1'b1);
    launch(v);
    for (int l = 0; l < 4; l++) begin
      logic [31:0] off;
      off = (l == 0) ? 32'd0 : (l == 1) ? 32'd64 : (l == 2) ? 32'd96 : 32'd112;
      chk(addr == v.base + off, "R6", "example offset", addr, v.base + off);
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
    end

    // R3 pitch exactly equal to row size is accepted
    v = '{32'h0003_0000, 5'd6, 12'd32, 12'd2, 2'd1, 1'b0};
    launch(v);
    chk(err == 1'b0 && valid == 1'b1, "R3", "pitch equal accepted", {err, valid}, 2'b01);
    walk(v, 1'b1);

    // R9 bad start followed by good start clears err
    expect_err(VECS[6]);
    v = VECS[1];
    launch(v);
    chk(err == 1'b0 && valid == 1'b1, "R9", "err cleared by good start", {err, valid}, 2'b01);
    walk(v, 1'b1);

    // R8 first record presented in the cycle after start
    @(negedge clk);
    v = VECS[3];
    base = v.base; pl = v.pl; w = v.w; h = v.h; bpt = v.bpt;
    chk(valid == 1'b0, "R8", "no record before start", valid, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b1 && lvl == '0, "R8", "record one cycle after start", valid, 1);
    walk(v, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule